// File: doc/BRIEF.md
# Split-Phase Load Port with Stack Pointer

This block is the load side of a small 16-bit processor, split into two phases. A request instruction gives a base register value and an immediate offset. Their 16-bit sum goes to on-chip memory. The returned word goes into an in-order result queue. A later retrieve instruction takes the oldest queued word. Several requests may be issued back to back, and retrieves then return their words in issue order.

The address space has two regions. Addresses below 0x8000 belong to the main code/data RAM of 16384 words. The upper half of that space, 0x4000 to 0x7FFF, folds onto the lower half. Addresses from 0x8000 upward select the control region, which holds data only. There is a single dynamic chip select, and every access (request, pop or push) updates it. When the memory word comes back, it is taken from whichever region is selected at that moment. If requests to different regions are mixed in flight, the last one decides the region for all of them.

The block also owns the stack pointer. A push pre-decrements the pointer and writes the word there. A pop request reads at the pointer, then increments it, and its result is retrieved through the same queue as a load. The memories are outside the block: it drives one shared word address, a region select, a write enable and write data, and it expects each region to return the word one cycle after it sees the address.

Top module: `split_load_port`

## Requirements
- R1: After reset, `sp` is 0x8000, `ret_data` is 0, and `ret_err` and `mem_we` are 0.
- R2: An accepted request uses the address `rq_base + rq_offset` (modulo 2^16). In the cycle after the request, `mem_sel_ctrl` equals bit 15 of that address. `mem_addr` equals bits 14:0 when bit 15 is 1; otherwise it equals bits 13:0 zero-extended, so 0x4000 to 0x7FFF fold onto 0x0000 to 0x3FFF.
- R3: A retrieve issued in the third cycle after its request returns the requested word on `ret_data` in the cycle after the retrieve, with `ret_err` low.
- R4: Requests issued on consecutive cycles are retrieved in issue order.
- R5: A returning word is taken from the region selected by the most recent access (request, pop or push) at the cycle it arrives. Mixing regions in flight makes every pending word come from the last-selected region.
- R6: A retrieve when no word is queued gives `ret_data` = 0 and `ret_err` = 1 in the next cycle. A retrieve that finds a queued word gives `ret_err` = 0.
- R7: At most DEPTH (4) requests and pops may be outstanding, meaning issued but not yet retrieved. A further request or pop is ignored: the address, select and `sp` stay unchanged, and no extra word is queued.
- R8: A push decrements `sp`. In the next cycle it drives `mem_we` = 1 for one cycle, with the address decoded from the new `sp` (as in R2) and `mem_wdata` = `push_data`.
- R9: A pop reads at the current `sp`, decoded as in R2, then increments `sp`. Its word is retrieved like a load.
- R10: If several strobes are raised in one cycle, a request beats a pop, and a pop beats a push. The losing strobes have no effect.
- R11: In a cycle with no request, pop or push strobe, `sp` and `mem_sel_ctrl` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Load request strobe |
| rq_base | input | 16 | Base register value of the request |
| rq_offset | input | 16 | Immediate offset of the request |
| pop_valid | input | 1 | Pop request strobe |
| push_valid | input | 1 | Push strobe |
| push_data | input | 16 | Word to push |
| ret_valid | input | 1 | Retrieve strobe |
| main_rdata | input | 16 | Read word from the main RAM |
| ctrl_rdata | input | 16 | Read word from the control region |
| mem_addr | output | 15 | Word address within the selected region |
| mem_sel_ctrl | output | 1 | Region select, 1 = control, 0 = main |
| mem_we | output | 1 | Write enable for a push |
| mem_wdata | output | 16 | Write data for a push |
| ret_data | output | 16 | Retrieved word |
| ret_err | output | 1 | Retrieve found nothing queued |
| sp | output | 16 | Stack pointer |

## Verification
The hardest case to reach is the region clash. A main-RAM request must still be in flight when a control-region request re-steers the select, so that its word is silently fetched from the wrong region. The bench issues the two requests on consecutive cycles. It gives the two memory models distinct contents, so the word returned for the first request can only have come from the control region at the first request's offset. The capacity limit is reached by filling the queue with back-to-back requests. A request and a pop are then offered while it is full, and the bench observes that neither the address, the stack pointer nor the number of returned words changes.

// File: rtl/split_load_port.sv
module split_load_port #(
  parameter int DEPTH   = 4,
  parameter int MAIN_AW = 14,
  parameter logic [15:0] SP_INIT = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rq_valid,
  input  logic [15:0] rq_base,
  input  logic [15:0] rq_offset,
  input  logic        pop_valid,
  input  logic        push_valid,
  input  logic [15:0] push_data,
  input  logic        ret_valid,
  input  logic [15:0] main_rdata,
  input  logic [15:0] ctrl_rdata,
  output logic [14:0] mem_addr,
  output logic        mem_sel_ctrl,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  output logic [15:0] ret_data,
  output logic        ret_err,
  output logic [15:0] sp
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [15:0] sp_q, addr_q, wdata_q, ret_q;
  logic        sel_q, we_q, v1_q, v2_q, err_q;
  logic [CW-1:0] cnt_q, owed_q;
  logic [PW-1:0] wp_q, rp_q;
  logic [15:0]   q_mem [DEPTH];

  wire        room     = owed_q < FULL;
  wire        take_rq  = rq_valid && room;
  wire        take_pop = !rq_valid && pop_valid && room;
  wire        take_psh = !rq_valid && !pop_valid && push_valid;
  wire        issue    = take_rq || take_pop;
  wire [15:0] nxt_addr = take_rq ? (rq_base + rq_offset) : take_pop ? sp_q : sp_q - 16'd1;
  wire        deq      = ret_valid && (cnt_q != '0);
  wire [15:0] rd_word  = sel_q ? ctrl_rdata : main_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q   <= SP_INIT;
      addr_q <= '0;
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      wdata_q <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      cnt_q  <= '0;
      owed_q <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      ret_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (issue || take_psh) begin
        addr_q <= nxt_addr;
        sel_q  <= nxt_addr[15];
      end
      if (take_pop) sp_q <= sp_q + 16'd1;
      else if (take_psh) sp_q <= sp_q - 16'd1;
      we_q    <= take_psh;
      wdata_q <= push_data;
      v1_q    <= issue;
      v2_q    <= v1_q;
      if (v2_q) wp_q <= wp_q + PW'(1);
      if (deq)  rp_q <= rp_q + PW'(1);
      cnt_q  <= cnt_q + CW'(v2_q) - CW'(deq);
      owed_q <= owed_q + CW'(issue) - CW'(deq);
      if (ret_valid) ret_q <= deq ? q_mem[rp_q] : '0;
      err_q <= ret_valid && !deq;
    end
  end

  always_ff @(posedge clk)
    if (v2_q) q_mem[wp_q] <= rd_word;

  assign mem_addr     = sel_q ? addr_q[14:0] : 15'(addr_q[MAIN_AW-1:0]);
  assign mem_sel_ctrl = sel_q;
  assign mem_we       = we_q;
  assign mem_wdata    = wdata_q;
  assign ret_data     = ret_q;
  assign ret_err      = err_q;
  assign sp           = sp_q;
endmodule

// File: rtl/split_load_port_chk.sv
module split_load_port_chk #(
  parameter int CW = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rq_valid,
  input logic [15:0]   rq_base,
  input logic [15:0]   rq_offset,
  input logic          pop_valid,
  input logic          push_valid,
  input logic          ret_valid,
  input logic [14:0]   mem_addr,
  input logic          mem_sel_ctrl,
  input logic          ret_err,
  input logic [15:0]   ret_data,
  input logic [15:0]   sp,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] owed
);
  logic [15:0] ra;
  assign ra = rq_base + rq_offset;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CW'(DEPTH));

  assert_empty_retrieve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && cnt == '0) |=> (ret_err && ret_data == 16'd0));

  assert_err_only_on_retrieve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !ret_err);

  assert_main_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && owed < CW'(DEPTH) && !ra[15]) |=>
      (!mem_sel_ctrl && mem_addr == {1'b0, $past(ra[13:0])}));

  assert_pop_incr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !rq_valid && owed < CW'(DEPTH)) |=> sp == $past(sp) + 16'd1);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rq_valid && !pop_valid && !push_valid) |=> ($stable(sp) && $stable(mem_sel_ctrl)));
endmodule

bind split_load_port split_load_port_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_base(rq_base),
  .rq_offset(rq_offset), .pop_valid(pop_valid), .push_valid(push_valid),
  .ret_valid(ret_valid), .mem_addr(mem_addr), .mem_sel_ctrl(mem_sel_ctrl),
  .ret_err(ret_err), .ret_data(ret_data), .sp(sp), .cnt(cnt_q), .owed(owed_q)
);

// File: tb/split_load_port_test.sv
module split_load_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rq_valid = 0, pop_valid = 0, push_valid = 0, ret_valid = 0;
  logic [15:0] rq_base = 0, rq_offset = 0, push_data = 0;
  logic [15:0] main_rdata = 0, ctrl_rdata = 0;
  logic [14:0] mem_addr;
  logic mem_sel_ctrl, mem_we, ret_err;
  logic [15:0] mem_wdata, ret_data, sp;

  logic [15:0] main_arr [16];
  logic [15:0] ctrl_arr [16];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_load_port uut (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_base(rq_base),
    .rq_offset(rq_offset), .pop_valid(pop_valid), .push_valid(push_valid),
    .push_data(push_data), .ret_valid(ret_valid), .main_rdata(main_rdata),
    .ctrl_rdata(ctrl_rdata), .mem_addr(mem_addr), .mem_sel_ctrl(mem_sel_ctrl),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .ret_data(ret_data),
    .ret_err(ret_err), .sp(sp)
  );

  initial for (int i = 0; i < 16; i++) begin
    main_arr[i] = 16'h1000 + 16'(i);
    ctrl_arr[i] = 16'hC000 + 16'(i);
  end

  always @(posedge clk) begin
    main_rdata <= main_arr[mem_addr[3:0]];
    ctrl_rdata <= ctrl_arr[mem_addr[3:0]];
    if (mem_we) begin
      if (mem_sel_ctrl) ctrl_arr[mem_addr[3:0]] <= mem_wdata;
      else main_arr[mem_addr[3:0]] <= mem_wdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [15:0] b, logic [15:0] o);
    rq_valid = 1; rq_base = b; rq_offset = o;
    @(negedge clk);
    rq_valid = 0;
  endtask

  task automatic retrieve(string req, logic [15:0] exp, logic exp_err);
    ret_valid = 1;
    @(negedge clk);
    ret_valid = 0;
    check(req, ret_data, exp);
    check(req, ret_err, exp_err);
  endtask

  task automatic t_reset;
    check("R1 sp", sp, 16'h8000);
    check("R1 ret_data", ret_data, 0);
    check("R1 ret_err", ret_err, 0);
    check("R1 mem_we", mem_we, 0);
  endtask

  task automatic t_single;
    issue(16'h0010, 16'hFFF5);
    check("R2 main addr", mem_addr, 15'h0005);
    check("R2 main sel", mem_sel_ctrl, 0);
    idle(2);
    retrieve("R3 single load", 16'h1005, 0);
  endtask

  task automatic t_mirror_ctrl;
    issue(16'h4000, 16'h0003);
    check("R2 mirror addr", mem_addr, 15'h0003);
    check("R2 mirror sel", mem_sel_ctrl, 0);
    idle(2);
    retrieve("R2 mirror data", 16'h1003, 0);
    issue(16'h8100, 16'h0007);
    check("R2 ctrl addr", mem_addr, 15'h0107);
    check("R2 ctrl sel", mem_sel_ctrl, 1);
    idle(2);
    retrieve("R2 ctrl data", 16'hC007, 0);
  endtask

  task automatic t_order;
    issue(16'h0001, 0);
    issue(16'h0009, 0);
    issue(16'h0004, 0);
    idle(2);
    retrieve("R4 order 0", 16'h1001, 0);
    retrieve("R4 order 1", 16'h1009, 0);
    retrieve("R4 order 2", 16'h1004, 0);
  endtask

  task automatic t_last_wins;
    issue(16'h0002, 0);
    issue(16'h8005, 0);
    idle(2);
    retrieve("R5 first from ctrl", 16'hC002, 0);
    retrieve("R5 second from ctrl", 16'hC005, 0);
  endtask

  task automatic t_empty;
    retrieve("R6 empty retrieve", 16'h0000, 1);
    idle(1);
    check("R6 err clears", ret_err, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) issue(16'(i + 8), 0);
    issue(16'h000E, 0);
    check("R7 ignored addr", mem_addr, 15'h000B);
    pop_valid = 1;
    @(negedge clk);
    pop_valid = 0;
    check("R7 ignored pop sp", sp, 16'h8000);
    idle(2);
    for (int i = 0; i < 4; i++) retrieve("R7 queued word", 16'h1008 + 16'(i), 0);
    retrieve("R7 no extra word", 16'h0000, 1);
  endtask

  task automatic t_push_pop;
    push_valid = 1; push_data = 16'hBEEF;
    @(negedge clk);
    push_valid = 0;
    check("R8 sp dec", sp, 16'h7FFF);
    check("R8 we", mem_we, 1);
    check("R8 addr", mem_addr, 15'h3FFF);
    check("R8 wdata", mem_wdata, 16'hBEEF);
    idle(1);
    check("R8 we one cycle", mem_we, 0);
    pop_valid = 1;
    @(negedge clk);
    pop_valid = 0;
    check("R9 sp inc", sp, 16'h8000);
    check("R9 pop addr", mem_addr, 15'h3FFF);
    idle(2);
    retrieve("R9 pop data", 16'hBEEF, 0);
    pop_valid = 1;
    @(negedge clk);
    pop_valid = 0;
    check("R9 pop ctrl sel", mem_sel_ctrl, 1);
    idle(2);
    retrieve("R9 pop at 8000", 16'hC000, 0);
    check("R9 sp", sp, 16'h8001);
  endtask

  task automatic t_priority;
    rq_valid = 1; rq_base = 16'h0006; rq_offset = 0; pop_valid = 1; push_valid = 1;
    @(negedge clk);
    rq_valid = 0; pop_valid = 0; push_valid = 0;
    check("R10 sp unchanged", sp, 16'h8001);
    check("R10 no write", mem_we, 0);
    check("R10 rq wins addr", mem_addr, 15'h0006);
    idle(2);
    retrieve("R10 one word", 16'h1006, 0);
    retrieve("R10 only one", 16'h0000, 1);
    pop_valid = 1; push_valid = 1;
    @(negedge clk);
    pop_valid = 0; push_valid = 0;
    check("R10 pop beats push", sp, 16'h8002);
    check("R10 pop no write", mem_we, 0);
    idle(3);
    check("R11 idle sp", sp, 16'h8002);
    retrieve("R10 pop word", 16'hC001, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(1);
    t_single();
    t_mirror_ctrl();
    t_order();
    t_last_wins();
    t_empty();
    t_full();
    t_push_pop();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule